// File: doc/BRIEF.md
# Parallel Converter Sampling Controller

This block sits on the digital side of a 14-bit successive-approximation converter with a parallel output bus. It issues the converter's active-low start strobe at a programmed sample period. It follows the converter's active-low busy line through a synchronizer and reads the output word and the out-of-range flag at the moment a new conversion begins. The word on the bus at that moment is the result of the conversion before. The block therefore tags each word with the index of the conversion that produced it, and delivers it on a valid/ready stream with decoded overrange and underrange bits.

The block also owns the converter's two low-power lines (a light nap and a deep sleep, both active low) and its 2-bit input-span select. A power or span change takes effect only between conversions. A release from nap or from sleep holds off the next strobe for its own wake-up time. A span change holds off strobes for a settling time that depends on the direction of the change. The held result that such an event makes stale is discarded, so no word from before the event reaches the stream. All times are counted in system clock cycles and set by parameters.

Top module: `adc_capture_ctrl`

## Requirements
- R1: After reset the strobe and both low-power lines are high, the span output is code 3 (widest span), the stream is not valid and the drop flag is clear.
- R2: Each start strobe stays low for exactly STRB_LOW clock cycles.
- R3: While enable is high and nothing holds strobes off, successive strobe falling edges are spaced by max(period_cyc, MIN_PERIOD) cycles. While enable is low, no strobe is issued.
- R4: No strobe is issued while a conversion is pending. A conversion is pending from its strobe until busy is seen high again.
- R5: The data word and flag on the converter bus are read when busy falls. They are output with the tag (index of the previous conversion) mod 2^SEQ_W, where conversions are numbered from 0 after reset. The word read at the first busy fall after reset is discarded.
- R6: Bit 13 is the sign bit. Overrange is flag=1 with bit 13=0. Underrange is flag=1 with bit 13=1. Both are 0 when flag=0.
- R7: While nap_req is high, the nap line is driven low from the first cycle with no pending conversion, and no strobe is issued. The first strobe after the nap line returns high falls NAP_WAKE to NAP_WAKE+2 cycles later.
- R8: The sleep line behaves in the same way, using sleep_req and SLEEP_WAKE. When both lines are released together, the longer wait applies.
- R9: The span output takes the value of range_sel when no conversion is pending. Codes run from 3 (widest) to 0 (narrowest). After a change, the first strobe falls D to D+2 cycles later. D is RANGE_UP_WAIT when the new code is larger, RANGE_DN_WAIT for a change from 3 to 2, and RANGE_LOW_WAIT for any other change.
- R10: While valid is high and ready is low, the output sample holds. A sample read while the output is still full is dropped, and smp_dropped becomes 1 and stays 1 until reset.
- R11: After a span change, or on entry into nap or sleep, the first word read afterwards is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows periodic conversions |
| period_cyc | input | CNT_W | Requested sample period in cycles (clamped to MIN_PERIOD) |
| nap_req | input | 1 | Requests nap power-down |
| sleep_req | input | 1 | Requests sleep power-down |
| range_sel | input | 2 | Requested input span code |
| adc_busy_n | input | 1 | Converter busy, low during conversion |
| adc_data | input | DATA_W | Converter parallel output word |
| adc_otr | input | 1 | Converter out-of-range flag |
| adc_convst_n | output | 1 | Start strobe, falling edge starts a conversion |
| adc_nap_n | output | 1 | Nap control, low = nap |
| adc_slp_n | output | 1 | Sleep control, low = sleep |
| adc_range | output | 2 | Span select driven to the converter |
| smp_valid | output | 1 | Output sample valid |
| smp_ready | input | 1 | Consumer accepts sample |
| smp_data | output | DATA_W | Signed sample word |
| smp_over | output | 1 | Sample was above the span |
| smp_under | output | 1 | Sample was below the span |
| smp_tag | output | SEQ_W | Index of the conversion that produced the sample |
| smp_dropped | output | 1 | Sticky: a sample was lost to a stalled consumer |

## Verification
The bench feeds a converter model whose words are a function of the conversion index. A controller that reads at the wrong edge, or that forgets the one-conversion lag, then shows up as a tag and data pair that do not match. A span change or power-down that fails to discard the stale word shows up as an extra sample in the stream. A strobe issued while the model is busy is flagged as an illegal restart. A strobe that comes too early after a nap or sleep release, or after each of the three kinds of span change, shows up in the measured gaps. The bench also checks the clamp of the sample period at both a short request and zero. It stalls the consumer over several conversions and checks that exactly the first sample of the stall survives and that the drop flag stays set afterwards.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    localparam logic [1:0] RANGE_WIDE = 2'd3;
    localparam logic [1:0] RANGE_MID  = 2'd2;

    typedef enum logic [1:0] {
        SETTLE_UP,
        SETTLE_DN,
        SETTLE_LOW
    } settle_e;

    // Direction class of a span change: larger code means wider span.
    function automatic settle_e settle_kind(input logic [1:0] old_c, input logic [1:0] new_c);
        if (new_c > old_c)
            return SETTLE_UP;
        else if (old_c == RANGE_WIDE && new_c == RANGE_MID)
            return SETTLE_DN;
        else
            return SETTLE_LOW;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n_in,
    output logic busy_s,
    output logic busy_fall,
    output logic busy_rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = busy_n_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        st_q <= st_d;
    end

    assign busy_s    = st_q.s2;
    assign busy_fall = st_q.prev & ~st_q.s2;
    assign busy_rise = ~st_q.prev & st_q.s2;

endmodule

// File: rtl/adc_gate_timer.sv
module adc_gate_timer #(
    parameter int CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             idle
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        // A new wait never shortens one already running.
        if (load && load_val > cnt_d)
            cnt_d = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle = (cnt_q == '0);

    AST_TMR_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !idle); // R7 R9

endmodule

// File: rtl/adc_sample_out.sv
module adc_sample_out #(
    parameter int DATA_W = 14,
    parameter int SEQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              cap_otr,
    input  logic [SEQ_W-1:0]  cap_tag,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              over,
    output logic              under,
    output logic [SEQ_W-1:0]  tag,
    output logic              dropped
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              over;
        logic              under;
        logic [SEQ_W-1:0]  tag;
        logic              dropped;
    } out_t;

    out_t st_d, st_q;
    logic sign_bit;

    assign sign_bit = cap_data[DATA_W-1];

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ready)
            st_d.valid = 1'b0;
        if (cap) begin
            if (!st_q.valid || ready) begin
                st_d.valid = 1'b1;
                st_d.data  = cap_data;
                st_d.over  = cap_otr & ~sign_bit;
                st_d.under = cap_otr & sign_bit;
                st_d.tag   = cap_tag;
            end else begin
                st_d.dropped = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid   = st_q.valid;
    assign data    = st_q.data;
    assign over    = st_q.over;
    assign under   = st_q.under;
    assign tag     = st_q.tag;
    assign dropped = st_q.dropped;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data) && $stable(tag))); // R10
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> dropped); // R10

endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
    parameter int DATA_W         = 14,
    parameter int SEQ_W          = 8,
    parameter int CNT_W          = 27,
    parameter int STRB_LOW       = 3,
    parameter int MIN_PERIOD     = 60,
    parameter int NAP_WAKE       = 32,
    parameter int SLEEP_WAKE     = 26_250_000,
    parameter int RANGE_UP_WAIT  = 75_000,
    parameter int RANGE_DN_WAIT  = 1_375_000,
    parameter int RANGE_LOW_WAIT = 87_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  period_cyc,
    input  logic              nap_req,
    input  logic              sleep_req,
    input  logic [1:0]        range_sel,
    input  logic              adc_busy_n,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              adc_otr,
    output logic              adc_convst_n,
    output logic              adc_nap_n,
    output logic              adc_slp_n,
    output logic [1:0]        adc_range,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_over,
    output logic              smp_under,
    output logic [SEQ_W-1:0]  smp_tag,
    output logic              smp_dropped
);
    import adc_cap_pkg::*;

    localparam int               STRB_W = $clog2(STRB_LOW + 1);
    localparam logic [CNT_W-1:0] MIN_P  = CNT_W'(MIN_PERIOD);

    typedef struct packed {
        logic              convst_n;
        logic [STRB_W-1:0] strb_cnt;
        logic [CNT_W-1:0]  pcnt;
        logic              conv;
        logic              nap_n;
        logic              slp_n;
        logic [1:0]        range;
        logic              have_prev;
        logic [SEQ_W-1:0]  seq;
        logic [SEQ_W-1:0]  cur;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             busy_s, busy_fall, busy_rise;
    logic             wake_load, settle_load, wake_idle, settle_idle;
    logic [CNT_W-1:0] wake_val, settle_val;
    logic [CNT_W-1:0] eff_m1;
    logic             cap, start, nap_rel, slp_rel, pwr_enter;

    function automatic logic [CNT_W-1:0] settle_cycles(input logic [1:0] old_c, input logic [1:0] new_c);
        case (settle_kind(old_c, new_c))
            SETTLE_UP: return CNT_W'(RANGE_UP_WAIT);
            SETTLE_DN: return CNT_W'(RANGE_DN_WAIT);
            default:   return CNT_W'(RANGE_LOW_WAIT);
        endcase
    endfunction

    adc_busy_sync u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_n_in (adc_busy_n),
        .busy_s    (busy_s),
        .busy_fall (busy_fall),
        .busy_rise (busy_rise)
    );

    adc_gate_timer #(.CNT_W(CNT_W)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_load),
        .load_val (wake_val),
        .idle     (wake_idle)
    );

    adc_gate_timer #(.CNT_W(CNT_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (settle_val),
        .idle     (settle_idle)
    );

    assign eff_m1 = ((period_cyc < MIN_P) ? MIN_P : period_cyc) - 1'b1;

    always_comb begin
        st_d        = st_q;
        cap         = 1'b0;
        settle_load = 1'b0;
        settle_val  = '0;

        // Strobe low phase
        if (!st_q.convst_n) begin
            if (st_q.strb_cnt == '0) st_d.convst_n = 1'b1;
            else                     st_d.strb_cnt = st_q.strb_cnt - 1'b1;
        end

        // Saturating cycles-since-strobe count
        if (st_q.pcnt != '1)
            st_d.pcnt = st_q.pcnt + 1'b1;

        // Conversion tracking and capture of the previous result
        if (busy_rise)
            st_d.conv = 1'b0;
        if (busy_fall) begin
            cap            = st_q.have_prev;
            st_d.have_prev = 1'b1;
        end

        // Power and span updates only between conversions
        if (!st_q.conv) begin
            st_d.nap_n = ~nap_req;
            st_d.slp_n = ~sleep_req;
            if (range_sel != st_q.range) begin
                st_d.range  = range_sel;
                settle_load = 1'b1;
                settle_val  = settle_cycles(st_q.range, range_sel);
            end
        end

        nap_rel   = ~st_q.nap_n & st_d.nap_n;
        slp_rel   = ~st_q.slp_n & st_d.slp_n;
        pwr_enter = (st_q.nap_n & ~st_d.nap_n) | (st_q.slp_n & ~st_d.slp_n);
        if (pwr_enter || settle_load)
            st_d.have_prev = 1'b0;

        start = enable && !st_q.conv && st_q.convst_n && busy_s
             && st_q.nap_n && st_q.slp_n && !nap_req && !sleep_req
             && (range_sel == st_q.range) && wake_idle && settle_idle
             && (st_q.pcnt >= eff_m1);

        if (start) begin
            st_d.convst_n = 1'b0;
            st_d.strb_cnt = STRB_W'(STRB_LOW - 1);
            st_d.pcnt     = '0;
            st_d.conv     = 1'b1;
            st_d.cur      = st_q.seq;
            st_d.seq      = st_q.seq + 1'b1;
        end
    end

    assign wake_load = nap_rel | slp_rel;
    assign wake_val  = slp_rel ? CNT_W'(SLEEP_WAKE) : CNT_W'(NAP_WAKE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.convst_n <= 1'b1;
            st_q.nap_n    <= 1'b1;
            st_q.slp_n    <= 1'b1;
            st_q.range    <= RANGE_WIDE;
        end else begin
            st_q <= st_d;
        end
    end

    adc_sample_out #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .cap_data (adc_data),
        .cap_otr  (adc_otr),
        .cap_tag  (st_q.cur - 1'b1),
        .ready    (smp_ready),
        .valid    (smp_valid),
        .data     (smp_data),
        .over     (smp_over),
        .under    (smp_under),
        .tag      (smp_tag),
        .dropped  (smp_dropped)
    );

    assign adc_convst_n = st_q.convst_n;
    assign adc_nap_n    = st_q.nap_n;
    assign adc_slp_n    = st_q.slp_n;
    assign adc_range    = st_q.range;

    AST_STRB_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |-> $past(busy_s)); // R4
    AST_STRB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |-> ($past(wake_idle) && $past(settle_idle) && adc_nap_n && adc_slp_n)); // R7
    AST_RANGE_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_range) |-> !$past(st_q.conv)); // R9
    AST_PWR_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_nap_n) || $fell(adc_slp_n)) |-> !$past(st_q.conv)); // R8

endmodule

// File: tb/adc_capture_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_capture_ctrl_tb_top;

    localparam int DATA_W   = 14;
    localparam int SEQ_W    = 8;
    localparam int CNT_W    = 16;
    localparam int STRB_LOW = 3;
    localparam int MIN_P    = 48;
    localparam int NAP_W    = 32;
    localparam int SLEEP_W  = 400;
    localparam int RUP_W    = 100;
    localparam int RDN_W    = 200;
    localparam int RLOW_W   = 300;
    localparam int CONV_CYC = 34;
    localparam int WDOG_CYC = 150000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [CNT_W-1:0]  period_cyc = 16'd20;
    logic              nap_req = 1'b0, sleep_req = 1'b0;
    logic [1:0]        range_sel = 2'd3;
    logic              smp_ready = 1'b1;
    logic              adc_convst_n, adc_nap_n, adc_slp_n;
    logic [1:0]        adc_range;
    logic              smp_valid, smp_over, smp_under, smp_dropped;
    logic [DATA_W-1:0] smp_data;
    logic [SEQ_W-1:0]  smp_tag;

    logic              stub_busy_n = 1'b1;
    logic [DATA_W-1:0] stub_data = '0;
    logic              stub_otr = 1'b0;

    adc_capture_ctrl #(
        .DATA_W(DATA_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .STRB_LOW(STRB_LOW),
        .MIN_PERIOD(MIN_P), .NAP_WAKE(NAP_W), .SLEEP_WAKE(SLEEP_W),
        .RANGE_UP_WAIT(RUP_W), .RANGE_DN_WAIT(RDN_W), .RANGE_LOW_WAIT(RLOW_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period_cyc(period_cyc),
        .nap_req(nap_req), .sleep_req(sleep_req), .range_sel(range_sel),
        .adc_busy_n(stub_busy_n), .adc_data(stub_data), .adc_otr(stub_otr),
        .adc_convst_n(adc_convst_n), .adc_nap_n(adc_nap_n), .adc_slp_n(adc_slp_n),
        .adc_range(adc_range), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_data(smp_data), .smp_over(smp_over), .smp_under(smp_under),
        .smp_tag(smp_tag), .smp_dropped(smp_dropped)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input longint got, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] word_of(input int k);
        return DATA_W'(k * 1237 + 8150);
    endfunction

    function automatic logic otr_of(input int k);
        return (k % 3) == 1;
    endfunction

    // Behavioural model state
    int  exp_q[$];
    bit  mdl_prev_ok = 1'b0;
    bit  stalled     = 1'b0;
    bit  stall_held  = 1'b0;
    bit  exp_drop    = 1'b0;
    int  stub_k      = 0;
    int  stub_cnt    = 0;
    bit  stub_post   = 1'b0;
    logic cv_prev    = 1'b1;
    int  n_falls     = 0;

    // Converter stub: busy low for CONV_CYC cycles, new word one cycle after busy rises
    always @(posedge clk) begin
        cv_prev <= adc_convst_n;
        if (rst_n && cv_prev && !adc_convst_n) begin
            n_falls++;
            check(stub_busy_n && stub_cnt == 0 && !stub_post, "R4", "strobe during conversion", 1, 0);
            check(adc_nap_n && adc_slp_n, "R7", "strobe while powered down", {adc_nap_n, adc_slp_n}, 3);
            if (mdl_prev_ok) begin
                if (stalled) begin
                    if (!stall_held) begin
                        exp_q.push_back(stub_k - 1);
                        stall_held = 1'b1;
                    end else begin
                        exp_drop = 1'b1;
                    end
                end else begin
                    exp_q.push_back(stub_k - 1);
                end
            end
            mdl_prev_ok = 1'b1;
            stub_k++;
            stub_busy_n <= 1'b0;
            stub_cnt    <= CONV_CYC;
        end else if (stub_cnt > 0) begin
            if (stub_cnt == 1) begin
                stub_busy_n <= 1'b1;
                stub_post   <= 1'b1;
            end
            stub_cnt <= stub_cnt - 1;
        end else if (stub_post) begin
            stub_data <= word_of(stub_k - 1);
            stub_otr  <= otr_of(stub_k - 1);
            stub_post <= 1'b0;
        end
    end

    // Stream comparison against the model, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && smp_valid && smp_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected sample tag", smp_tag, -1);
            end else begin
                int k;
                logic [DATA_W-1:0] w;
                k = exp_q.pop_front();
                w = word_of(k);
                check(smp_tag == SEQ_W'(k), "R5 R11", "sample tag", smp_tag, k % 256);
                check(smp_data == w, "R5", "sample data", smp_data, w);
                check(smp_over == (otr_of(k) & ~w[DATA_W-1]), "R6", "overrange", smp_over, otr_of(k) & ~w[DATA_W-1]);
                check(smp_under == (otr_of(k) & w[DATA_W-1]), "R6", "underrange", smp_under, otr_of(k) & w[DATA_W-1]);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_busy_rise();
        @(posedge stub_busy_n);
        #1;
    endtask

    task automatic measure_period(input int exp, input string req);
        time t0, t1;
        @(negedge adc_convst_n); t0 = $time;
        @(negedge adc_convst_n); t1 = $time;
        check((t1 - t0) == exp * 8, req, "strobe spacing", (t1 - t0) / 8, exp);
    endtask

    task automatic gap_check(input time t0, input int lo, input string req, input string what);
        time t1;
        longint cyc;
        @(negedge adc_convst_n); t1 = $time;
        cyc = (t1 - t0) / 8;
        check(cyc >= lo && cyc <= lo + 2, req, what, cyc, lo);
    endtask

    task automatic range_step(input logic [1:0] v, input int d, input string what);
        time t0;
        wait_busy_rise();
        range_sel   = v;
        mdl_prev_ok = 1'b0;
        wait (adc_range == v);
        t0 = $time;
        check(adc_range == v, "R9", "span output", adc_range, v);
        gap_check(t0, d, "R9", what);
        tick(MIN_P * 3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int f0;
        time t0, t1;
        tick(5);
        rst_n = 1'b1;
        @(negedge clk);
        check(adc_convst_n == 1'b1, "R1", "strobe idle", adc_convst_n, 1);
        check(adc_nap_n == 1'b1 && adc_slp_n == 1'b1, "R1", "power lines", {adc_nap_n, adc_slp_n}, 3);
        check(adc_range == 2'd3, "R1", "span reset", adc_range, 3);
        check(smp_valid == 1'b0 && smp_dropped == 1'b0, "R1", "stream idle", {smp_valid, smp_dropped}, 0);

        f0 = n_falls;
        tick(100);
        check(n_falls == f0, "R3", "strobes while disabled", n_falls - f0, 0);

        // Clamped period, strobe width
        enable = 1'b1;
        @(negedge adc_convst_n); t0 = $time;
        @(posedge adc_convst_n); t1 = $time;
        check((t1 - t0) == STRB_LOW * 8, "R2", "strobe low width", (t1 - t0) / 8, STRB_LOW);
        measure_period(MIN_P, "R3");
        measure_period(MIN_P, "R3");

        // Longer requested period
        period_cyc = 16'd70;
        @(negedge adc_convst_n);
        measure_period(70, "R3");
        period_cyc = 16'd0;
        @(negedge adc_convst_n);
        measure_period(MIN_P, "R3");

        // Consumer stall across several conversions
        wait_busy_rise();
        smp_ready = 1'b0;
        stalled   = 1'b1;
        repeat (4) wait_busy_rise();
        check(smp_valid == 1'b1, "R10", "held sample valid", smp_valid, 1);
        check(smp_dropped == exp_drop, "R10", "drop flag set", smp_dropped, exp_drop);
        smp_ready  = 1'b1;
        stalled    = 1'b0;
        stall_held = 1'b0;
        repeat (2) wait_busy_rise();
        check(smp_dropped == 1'b1, "R10", "drop flag sticky", smp_dropped, 1);

        // Nap
        wait_busy_rise();
        nap_req     = 1'b1;
        mdl_prev_ok = 1'b0;
        tick(60);
        check(adc_nap_n == 1'b0, "R7", "nap line low", adc_nap_n, 0);
        f0 = n_falls;
        tick(40);
        check(n_falls == f0, "R7", "strobes during nap", n_falls - f0, 0);
        nap_req = 1'b0;
        @(posedge adc_nap_n); t0 = $time;
        gap_check(t0, NAP_W, "R7", "nap wake gap");
        tick(MIN_P * 3);

        // Sleep
        wait_busy_rise();
        sleep_req   = 1'b1;
        mdl_prev_ok = 1'b0;
        tick(60);
        check(adc_slp_n == 1'b0, "R8", "sleep line low", adc_slp_n, 0);
        f0 = n_falls;
        tick(40);
        check(n_falls == f0, "R8", "strobes during sleep", n_falls - f0, 0);
        sleep_req = 1'b0;
        @(posedge adc_slp_n); t0 = $time;
        gap_check(t0, SLEEP_W, "R8", "sleep wake gap");
        tick(MIN_P * 3);

        // Span changes of each class
        range_step(2'd2, RDN_W,  "settle 3 to 2");
        range_step(2'd3, RUP_W,  "settle 2 to 3");
        range_step(2'd0, RLOW_W, "settle 3 to 0");
        range_step(2'd1, RUP_W,  "settle 0 to 1");

        // Drain
        wait_busy_rise();
        enable = 1'b0;
        tick(60);
        f0 = n_falls;
        tick(200);
        check(n_falls == f0, "R3", "strobes after disable", n_falls - f0, 0);
        check(exp_q.size() == 0, "R5", "samples left unseen", exp_q.size(), 0);
        finish_run();
    end

endmodule